// File: doc/BRIEF.md
# Atomic Fetch-and-Modify Unit

This unit executes a family of read-modify-write atomic instructions for a 64-bit core. Given a 32-bit instruction word, the value of the base register and the value of the source register, it checks that the word belongs to the family, works out the operation and its size, and reads then writes one memory location over a single-port request interface. The lock stays raised throughout, so no other requester can slip in between the read and the write. The old memory contents go back to the register file on a write-back port, tagged with the destination index.

Six operations exist, each at word (32-bit) and doubleword (64-bit) size. Increment and decrement change the location by one, add sums in the source register, set fills it with ones, clear zeroes it, and swap stores the source register. The address is the base register value with no offset. Misaligned accesses, and doubleword accesses while 64-bit operation is disabled, raise a fault and leave memory alone. Words that are not in the family raise a miss pulse and are dropped.

Control is a four-state machine. ST_IDLE accepts an instruction and, if it is valid and clean, moves to ST_READ. Otherwise it raises a pulse and stays in ST_IDLE. ST_READ holds the read request until it is taken, then moves to ST_WAIT. ST_WAIT captures the read data and computes the new value, then moves to ST_WRITE. ST_WRITE holds the write request until it is taken, then returns to ST_IDLE.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset, issue_ready is 1 and mem_req_valid, mem_lock, wb_valid, fault and decode_miss are all 0.
- R2: An instruction is in the family only when bits [31:26] are 011100, bits [5:0] are 011111, and bits [10:6] hold one of 00010/00011 (increment), 00110/00111 (decrement), 10010/10011 (add), 01010/01011 (set), 01110/01111 (clear) or 10110/10111 (swap), where the odd code means doubleword. Any other accepted word gives a decode_miss pulse and no memory request.
- R3: For increment, decrement, set and clear, a nonzero source field in bits [20:16] makes the word a miss. Add and swap allow any source field.
- R4: Both requests carry mem_req_addr equal to issue_base, and mem_req_dw is 1 for doubleword and 0 for word.
- R5: The value written is old+1, old-1, old+source, all ones, zero, or the source value, wrapping at the access size.
- R6: Word data travels in bits [31:0] of mem_rsp_rdata and mem_req_wdata. Word operations ignore the upper source bits and the upper read-data bits.
- R7: wb_data is the old memory value, sign-extended from bit 31 for word operations. wb_idx is bits [15:11] of the instruction.
- R8: A word address with bits [1:0] nonzero, or a doubleword address with bits [2:0] nonzero, raises fault with no memory request and no write-back.
- R9: A doubleword operation while mode64_en is 0 raises fault with no memory request. Word operations still run.
- R10: mem_lock is high from the read request until the cycle the write is taken. A request that is not yet taken keeps mem_req_valid, mem_req_addr and mem_req_write stable.
- R11: With destination index 0 the memory update happens but wb_valid stays low.
- R12: issue_ready is low while an operation is in progress. An instruction held on the issue port is taken in the cycle after the previous write handshake.
- R13: fault and decode_miss pulse for one cycle, the cycle after acceptance. wb_valid pulses the cycle after the write handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode64_en | input | 1 | Permits doubleword operations |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Unit idle, instruction taken this cycle |
| issue_instr | input | 32 | Instruction word |
| issue_base | input | ADDR_W | Base register value (the address) |
| issue_src | input | XLEN | Source/addend register value |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request taken |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_dw | output | 1 | 1 doubleword, 0 word |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | XLEN | Write data |
| mem_lock | output | 1 | Exclusive hold over memory |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | XLEN | Read data |
| wb_valid | output | 1 | Write-back pulse |
| wb_idx | output | IDX_W | Destination register index |
| wb_data | output | XLEN | Old memory value |
| fault | output | 1 | Alignment or mode fault pulse |
| decode_miss | output | 1 | Word not in the family |

## Verification
A miss or fault is due exactly one cycle after the issue handshake, because the unit registers both pulses. A write-back is due exactly one cycle after the write handshake. The bench's monitor samples on the falling edge, stamps every handshake and pulse with its cycle number, and compares those stamps against these offsets, so stalls from the memory model cannot hide a lateness. The memory contents and the request count are checked only after the operation has settled. For back-to-back issue, the second acceptance must fall exactly one cycle after the first write handshake.

// File: rtl/amu_pkg.sv
package amu_pkg;
    localparam int INSN_W   = 32;
    localparam logic [5:0] MAJOR_OPC = 6'b011100;
    localparam logic [5:0] MINOR_OPC = 6'b011111;

    typedef enum logic [2:0] {
        OP_INC,
        OP_DEC,
        OP_ADD,
        OP_SET,
        OP_CLR,
        OP_SWP
    } amu_op_e;
endpackage

// File: rtl/amu_decode.sv
module amu_decode
    import amu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5,
    localparam int DW_LSB = $clog2(XLEN / 8),
    localparam int WD_LSB = DW_LSB - 1
) (
    input  logic [INSN_W-1:0] instr,
    input  logic [DW_LSB-1:0] addr_lo,
    input  logic              mode64_en,
    output logic              hit,
    output logic              bad_access,
    output amu_op_e           op,
    output logic              dw,
    output logic [IDX_W-1:0]  rd
);
    logic code_known;
    logic src_must_be_zero;
    logic src_zero;
    logic frame_ok;
    logic misaligned;
    logic unused_base_idx;

    assign unused_base_idx = ^instr[25:21];

    always_comb begin
        code_known       = 1'b1;
        src_must_be_zero = 1'b1;
        op               = OP_INC;
        unique case (instr[10:7])
            4'b0001: op = OP_INC;
            4'b0011: op = OP_DEC;
            4'b1001: begin op = OP_ADD; src_must_be_zero = 1'b0; end
            4'b0101: op = OP_SET;
            4'b0111: op = OP_CLR;
            4'b1011: begin op = OP_SWP; src_must_be_zero = 1'b0; end
            default: code_known = 1'b0;
        endcase
    end

    assign dw       = instr[6];
    assign rd       = instr[15:11];
    assign src_zero = (instr[20:16] == 5'd0);
    assign frame_ok = (instr[31:26] == MAJOR_OPC) && (instr[5:0] == MINOR_OPC);
    assign hit      = frame_ok && code_known && (src_zero || !src_must_be_zero);

    assign misaligned = dw ? (addr_lo != '0) : (addr_lo[WD_LSB-1:0] != '0);
    assign bad_access = misaligned || (dw && !mode64_en);
endmodule

// File: rtl/amu_alu.sv
module amu_alu
    import amu_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int HW = XLEN / 2
) (
    input  amu_op_e          op,
    input  logic             dw,
    input  logic [XLEN-1:0]  old_raw,
    input  logic [XLEN-1:0]  src,
    output logic [XLEN-1:0]  new_val,
    output logic [XLEN-1:0]  ret_val
);
    logic [XLEN-1:0] operand;
    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] full;

    always_comb begin
        unique case (op)
            OP_INC:  operand = XLEN'(1);
            OP_DEC:  operand = '1;
            OP_ADD:  operand = src;
            default: operand = '0;
        endcase
        sum = old_raw + operand;
        unique case (op)
            OP_INC, OP_DEC, OP_ADD: full = sum;
            OP_SET:  full = '1;
            OP_CLR:  full = '0;
            default: full = src;
        endcase
        new_val = dw ? full : {{HW{1'b0}}, full[HW-1:0]};
        ret_val = dw ? old_raw : {{HW{old_raw[HW-1]}}, old_raw[HW-1:0]};
    end
endmodule

// File: rtl/amu_ctrl.sv
module amu_ctrl
    import amu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  logic [ADDR_W-1:0] issue_base,
    input  logic [XLEN-1:0]   issue_src,
    input  logic              dec_hit,
    input  logic              dec_bad,
    input  amu_op_e           dec_op,
    input  logic              dec_dw,
    input  logic [IDX_W-1:0]  dec_rd,
    output amu_op_e           cur_op,
    output logic              cur_dw,
    output logic [XLEN-1:0]   cur_src,
    input  logic [XLEN-1:0]   alu_new,
    input  logic [XLEN-1:0]   alu_ret,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic              mem_req_dw,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [XLEN-1:0]   mem_req_wdata,
    output logic              mem_lock,
    input  logic              mem_rsp_valid,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic              fault,
    output logic              decode_miss
);
    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WAIT, ST_WRITE} st_e;

    st_e               state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [XLEN-1:0]   wdata_q;
    logic [XLEN-1:0]   ret_q;
    logic [IDX_W-1:0]  rd_q;
    logic              start;
    logic              wr_done;

    assign start   = issue_valid && dec_hit && !dec_bad;
    assign wr_done = (state == ST_WRITE) && mem_req_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)         state_nx = ST_READ;
            ST_READ:  if (mem_req_ready) state_nx = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_nx = ST_WRITE;
            ST_WRITE: if (mem_req_ready) state_nx = ST_IDLE;
            default:                     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        issue_ready   = (state == ST_IDLE);
        mem_req_valid = (state == ST_READ) || (state == ST_WRITE);
        mem_req_write = (state == ST_WRITE);
        mem_lock      = (state != ST_IDLE);
        mem_req_addr  = addr_q;
        mem_req_dw    = cur_dw;
        mem_req_wdata = (state == ST_WRITE) ? wdata_q : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            cur_src     <= '0;
            cur_op      <= OP_INC;
            cur_dw      <= 1'b0;
            rd_q        <= '0;
            wdata_q     <= '0;
            ret_q       <= '0;
            wb_valid    <= 1'b0;
            wb_idx      <= '0;
            wb_data     <= '0;
            fault       <= 1'b0;
            decode_miss <= 1'b0;
        end else begin
            wb_valid    <= 1'b0;
            fault       <= 1'b0;
            decode_miss <= 1'b0;
            unique case (state)
                ST_IDLE: if (issue_valid) begin
                    if (!dec_hit)     decode_miss <= 1'b1;
                    else if (dec_bad) fault <= 1'b1;
                    else begin
                        addr_q  <= issue_base;
                        cur_src <= issue_src;
                        cur_op  <= dec_op;
                        cur_dw  <= dec_dw;
                        rd_q    <= dec_rd;
                    end
                end
                ST_WAIT: if (mem_rsp_valid) begin
                    wdata_q <= alu_new;
                    ret_q   <= alu_ret;
                end
                ST_WRITE: if (mem_req_ready) begin
                    wb_valid <= (rd_q != '0);
                    wb_idx   <= rd_q;
                    wb_data  <= ret_q;
                end
                default: ;
            endcase
        end
    end

    AST_LOCK_UNTIL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_lock && !(mem_req_valid && mem_req_write && mem_req_ready) |=> mem_lock); // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)); // R10
    AST_BUSY_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_lock |-> !issue_ready); // R12
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !mem_req_valid && !wb_valid); // R8
    AST_WB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_idx != '0); // R11
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault, decode_miss, wb_valid})); // R13
    AST_WB_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(wr_done)); // R13
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import amu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode64_en,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  logic [31:0]       issue_instr,
    input  logic [ADDR_W-1:0] issue_base,
    input  logic [XLEN-1:0]   issue_src,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic              mem_req_dw,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [XLEN-1:0]   mem_req_wdata,
    output logic              mem_lock,
    input  logic              mem_rsp_valid,
    input  logic [XLEN-1:0]   mem_rsp_rdata,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic              fault,
    output logic              decode_miss
);
    localparam int DW_LSB = $clog2(XLEN / 8);
    localparam int WD_LSB = DW_LSB - 1;

    logic             dec_hit, dec_bad, dec_dw;
    amu_op_e          dec_op, cur_op;
    logic [IDX_W-1:0] dec_rd;
    logic             cur_dw;
    logic [XLEN-1:0]  cur_src, alu_new, alu_ret;

    amu_decode #(.XLEN(XLEN), .IDX_W(IDX_W)) u_dec (
        .instr      (issue_instr),
        .addr_lo    (issue_base[DW_LSB-1:0]),
        .mode64_en  (mode64_en),
        .hit        (dec_hit),
        .bad_access (dec_bad),
        .op         (dec_op),
        .dw         (dec_dw),
        .rd         (dec_rd)
    );

    amu_alu #(.XLEN(XLEN)) u_alu (
        .op      (cur_op),
        .dw      (cur_dw),
        .old_raw (mem_rsp_rdata),
        .src     (cur_src),
        .new_val (alu_new),
        .ret_val (alu_ret)
    );

    amu_ctrl #(.XLEN(XLEN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .issue_valid   (issue_valid),
        .issue_ready   (issue_ready),
        .issue_base    (issue_base),
        .issue_src     (issue_src),
        .dec_hit       (dec_hit),
        .dec_bad       (dec_bad),
        .dec_op        (dec_op),
        .dec_dw        (dec_dw),
        .dec_rd        (dec_rd),
        .cur_op        (cur_op),
        .cur_dw        (cur_dw),
        .cur_src       (cur_src),
        .alu_new       (alu_new),
        .alu_ret       (alu_ret),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_dw    (mem_req_dw),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_lock      (mem_lock),
        .mem_rsp_valid (mem_rsp_valid),
        .wb_valid      (wb_valid),
        .wb_idx        (wb_idx),
        .wb_data       (wb_data),
        .fault         (fault),
        .decode_miss   (decode_miss)
    );

    AST_ALIGNED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_dw ? (mem_req_addr[DW_LSB-1:0] == '0)
                                      : (mem_req_addr[WD_LSB-1:0] == '0))); // R8
    AST_MISS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        decode_miss |-> !mem_req_valid && !mem_lock); // R2
endmodule

// File: tb/sim_atomic_rmw_unit.sv
`timescale 1ns/1ps
module sim_atomic_rmw_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode64_en = 1'b1;
    logic        issue_valid = 1'b0;
    logic        issue_ready;
    logic [31:0] issue_instr = '0;
    logic [63:0] issue_base = '0;
    logic [63:0] issue_src = '0;
    logic        mem_req_valid, mem_req_write, mem_req_dw, mem_lock;
    logic        mem_req_ready = 1'b1;
    logic [63:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;
    logic        wb_valid, fault, decode_miss;
    logic [4:0]  wb_idx;
    logic [63:0] wb_data;

    always #2.5 clk = ~clk;

    atomic_rmw_unit u0 (.*);

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // memory model
    logic [63:0] mem [16];
    logic        stall_en = 1'b0;
    logic        pl_go = 1'b0;
    logic [3:0]  pl_idx = '0;
    logic [63:0] pl_val = '0;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_req_ready <= stall_en ? ~mem_req_ready : 1'b1;
        if (pl_go) mem[pl_idx] <= pl_val;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                if (mem_req_dw) mem[mem_req_addr[6:3]] <= mem_req_wdata;
                else if (mem_req_addr[2]) mem[mem_req_addr[6:3]][63:32] <= mem_req_wdata[31:0];
                else mem[mem_req_addr[6:3]][31:0] <= mem_req_wdata[31:0];
            end else begin
                mem_rsp_valid <= 1'b1;
                if (mem_req_dw) mem_rsp_rdata <= mem[mem_req_addr[6:3]];
                else mem_rsp_rdata <= {32'hA5A5_5A5A, mem_req_addr[2] ? mem[mem_req_addr[6:3]][63:32]
                                                                      : mem[mem_req_addr[6:3]][31:0]};
            end
        end
    end

    // monitor on the falling edge
    int acc_n = 0, rd_n = 0, wr_n = 0, wb_n = 0, fault_n = 0, miss_n = 0;
    int acc_cyc = 0, wr_cyc = 0, wb_cyc = 0, fault_cyc = 0, miss_cyc = 0, acc_prev_wr = 0;
    int lock_bad = 0, busy_bad = 0, hold_bad = 0;
    logic [63:0] last_addr = '0, last_wb_data = '0;
    logic        last_dw = 1'b0;
    logic [4:0]  last_wb_idx = '0;
    logic        prev_stall = 1'b0;
    logic [63:0] prev_addr = '0;
    logic        prev_write = 1'b0;

    always @(negedge clk) if (rst_n) begin
        if (issue_valid && issue_ready) begin acc_n++; acc_cyc = cyc; acc_prev_wr = wr_cyc; end
        if (mem_req_valid && mem_req_ready) begin
            last_addr = mem_req_addr;
            last_dw   = mem_req_dw;
            if (mem_req_write) begin wr_n++; wr_cyc = cyc; end else rd_n++;
        end
        if (wb_valid) begin wb_n++; wb_cyc = cyc; last_wb_data = wb_data; last_wb_idx = wb_idx; end
        if (fault) begin fault_n++; fault_cyc = cyc; end
        if (decode_miss) begin miss_n++; miss_cyc = cyc; end
        if (mem_req_valid && !mem_lock) lock_bad++;
        if (mem_lock && issue_ready) busy_bad++;
        if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr || mem_req_write != prev_write)) hold_bad++;
        prev_stall = mem_req_valid && !mem_req_ready;
        prev_addr  = mem_req_addr;
        prev_write = mem_req_write;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ins(input logic [5:0] maj, input logic [4:0] s,
                                        input logic [4:0] d, input logic [4:0] code,
                                        input logic [5:0] mn);
        return {maj, 5'd4, s, d, code, mn};
    endfunction

    localparam logic [5:0] MJ = 6'b011100;
    localparam logic [5:0] MN = 6'b011111;
    localparam logic [1:0] K_WB = 2'd0, K_NOWB = 2'd1, K_FAULT = 2'd2, K_MISS = 2'd3;

    typedef struct packed {
        logic [31:0] ins;
        logic [63:0] base;
        logic [63:0] src;
        logic [63:0] init;
        logic [63:0] ret;
        logic [63:0] mem_after;
        logic        m64;
        logic [1:0]  kind;
        logic        stall;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{ins(MJ,5'd0,5'd3, 5'b00010,MN), 64'h10, 64'h0, 64'hAAAA_AAAA_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF, 64'hAAAA_AAAA_8000_0000, 1'b1, K_WB, 1'b0},
        '{ins(MJ,5'd0,5'd4, 5'b00010,MN), 64'h14, 64'h0, 64'h8000_0000_1234_5678, 64'hFFFF_FFFF_8000_0000, 64'h8000_0001_1234_5678, 1'b1, K_WB, 1'b1},
        '{ins(MJ,5'd0,5'd5, 5'b00011,MN), 64'h18, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, K_WB, 1'b0},
        '{ins(MJ,5'd0,5'd6, 5'b00110,MN), 64'h20, 64'h0, 64'h1111_1111_0000_0000, 64'h0, 64'h1111_1111_FFFF_FFFF, 1'b1, K_WB, 1'b1},
        '{ins(MJ,5'd0,5'd7, 5'b00111,MN), 64'h28, 64'h0, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, K_WB, 1'b0},
        '{ins(MJ,5'd7,5'd8, 5'b10010,MN), 64'h30, 64'hDEAD_BEEF_0000_0005, 64'h5555_5555_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFE, 64'h5555_5555_0000_0003, 1'b1, K_WB, 1'b1},
        '{ins(MJ,5'd7,5'd9, 5'b10011,MN), 64'h38, 64'h1_0000_0001, 64'h2_FFFF_FFFF, 64'h2_FFFF_FFFF, 64'h4_0000_0000, 1'b1, K_WB, 1'b0},
        '{ins(MJ,5'd0,5'd10,5'b01010,MN), 64'h44, 64'h0, 64'h0000_0000_CAFE_F00D, 64'h0, 64'hFFFF_FFFF_CAFE_F00D, 1'b1, K_WB, 1'b1},
        '{ins(MJ,5'd0,5'd11,5'b01011,MN), 64'h48, 64'h0, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, K_WB, 1'b0},
        '{ins(MJ,5'd0,5'd12,5'b01110,MN), 64'h50, 64'h0, 64'h1234_5678_8765_4321, 64'hFFFF_FFFF_8765_4321, 64'h1234_5678_0000_0000, 1'b1, K_WB, 1'b1},
        '{ins(MJ,5'd0,5'd13,5'b01111,MN), 64'h58, 64'h0, 64'hF0F0, 64'hF0F0, 64'h0, 1'b1, K_WB, 1'b0},
        '{ins(MJ,5'd7,5'd14,5'b10110,MN), 64'h60, 64'hFFFF_FFFF_1357_9BDF, 64'h2468_ACE0_0BAD_0BAD, 64'h0BAD_0BAD, 64'h2468_ACE0_1357_9BDF, 1'b1, K_WB, 1'b1},
        '{ins(MJ,5'd7,5'd31,5'b10111,MN), 64'h68, 64'h0011_2233_4455_6677, 64'h99, 64'h99, 64'h0011_2233_4455_6677, 1'b1, K_WB, 1'b0},
        '{ins(MJ,5'd7,5'd0, 5'b10011,MN), 64'h70, 64'h1, 64'h41, 64'h0, 64'h42, 1'b1, K_NOWB, 1'b1},
        '{ins(MJ,5'd0,5'd3, 5'b00010,MN), 64'h22, 64'h0, 64'h5, 64'h0, 64'h5, 1'b1, K_FAULT, 1'b0},
        '{ins(MJ,5'd0,5'd3, 5'b00011,MN), 64'h0C, 64'h0, 64'h7, 64'h0, 64'h7, 1'b1, K_FAULT, 1'b0},
        '{ins(MJ,5'd0,5'd3, 5'b01011,MN), 64'h78, 64'h0, 64'h0, 64'h0, 64'h0, 1'b0, K_FAULT, 1'b0},
        '{ins(MJ,5'd0,5'd15,5'b01010,MN), 64'h78, 64'h0, 64'h0, 64'h0, 64'h0000_0000_FFFF_FFFF, 1'b0, K_WB, 1'b1},
        '{ins(MJ,5'd9,5'd3, 5'b00010,MN), 64'h08, 64'h0, 64'h3, 64'h0, 64'h3, 1'b1, K_MISS, 1'b0},
        '{ins(6'b011101,5'd7,5'd3,5'b10010,MN), 64'h08, 64'h1, 64'h3, 64'h0, 64'h3, 1'b1, K_MISS, 1'b0},
        '{ins(MJ,5'd7,5'd3, 5'b10010,6'b011110), 64'h08, 64'h1, 64'h3, 64'h0, 64'h3, 1'b1, K_MISS, 1'b0},
        '{ins(MJ,5'd0,5'd3, 5'b00000,MN), 64'h08, 64'h0, 64'h3, 64'h0, 64'h3, 1'b1, K_MISS, 1'b0}
    };

    task automatic preload(input logic [3:0] idx, input logic [63:0] val);
        @(negedge clk);
        pl_go = 1'b1; pl_idx = idx; pl_val = val;
        @(negedge clk);
        pl_go = 1'b0;
    endtask

    task automatic run_vec(input int i);
        vec_t v;
        int s_rd, s_wr, s_wb, s_f, s_m;
        string tag;
        v = VEC[i];
        tag = $sformatf("vec%0d", i);
        preload(v.base[6:3], v.init);
        stall_en  = v.stall;
        mode64_en = v.m64;
        s_rd = rd_n; s_wr = wr_n; s_wb = wb_n; s_f = fault_n; s_m = miss_n;
        issue_instr = v.ins; issue_base = v.base; issue_src = v.src; issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        for (int t = 0; t < 60; t++) begin
            if (wr_n > s_wr || fault_n > s_f || miss_n > s_m) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        stall_en = 1'b0;
        chk(mem[v.base[6:3]] == v.mem_after, "R5", {tag, " memory after"}, mem[v.base[6:3]], v.mem_after);
        unique case (v.kind)
            K_WB, K_NOWB: begin
                chk(rd_n - s_rd == 1 && wr_n - s_wr == 1, "R4", {tag, " one read one write"},
                    64'((rd_n - s_rd) * 16 + (wr_n - s_wr)), 64'h11);
                chk(last_addr == v.base && last_dw == v.ins[6], "R4", {tag, " address and size"},
                    last_addr, v.base);
                if (v.kind == K_WB) begin
                    chk(wb_n - s_wb == 1, "R13", {tag, " one write-back"}, 64'(wb_n - s_wb), 64'd1);
                    chk(last_wb_data == v.ret, "R7", {tag, " old value returned"}, last_wb_data, v.ret);
                    chk(last_wb_idx == v.ins[15:11], "R7", {tag, " index"}, 64'(last_wb_idx), 64'(v.ins[15:11]));
                    chk(wb_cyc == wr_cyc + 1, "R13", {tag, " write-back timing"}, 64'(wb_cyc), 64'(wr_cyc + 1));
                end else begin
                    chk(wb_n == s_wb, "R11", {tag, " no write-back for index 0"}, 64'(wb_n - s_wb), 64'd0);
                end
            end
            K_FAULT: begin
                chk(fault_n - s_f == 1, v.m64 ? "R8" : "R9", {tag, " fault pulse"}, 64'(fault_n - s_f), 64'd1);
                chk(rd_n == s_rd && wr_n == s_wr && wb_n == s_wb, v.m64 ? "R8" : "R9",
                    {tag, " no traffic"}, 64'(rd_n - s_rd + wr_n - s_wr + wb_n - s_wb), 64'd0);
                chk(fault_cyc == acc_cyc + 1, "R13", {tag, " fault timing"}, 64'(fault_cyc), 64'(acc_cyc + 1));
            end
            default: begin
                chk(miss_n - s_m == 1, (v.ins[20:16] != 0 && v.ins[10:7] == 4'b0001) ? "R3" : "R2",
                    {tag, " miss pulse"}, 64'(miss_n - s_m), 64'd1);
                chk(rd_n == s_rd && wr_n == s_wr && fault_n == s_f, "R2", {tag, " no traffic"},
                    64'(rd_n - s_rd + wr_n - s_wr), 64'd0);
                chk(miss_cyc == acc_cyc + 1, "R13", {tag, " miss timing"}, 64'(miss_cyc), 64'(acc_cyc + 1));
            end
        endcase
    endtask

    task automatic summary;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish");
        summary();
        $finish;
    end

    initial begin
        int s_acc, s_wr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(issue_ready === 1'b1, "R1", "issue_ready after reset", 64'(issue_ready), 64'd1);
        chk({mem_req_valid, mem_lock, wb_valid, fault, decode_miss} === 5'b0, "R1", "quiet after reset",
            64'({mem_req_valid, mem_lock, wb_valid, fault, decode_miss}), 64'd0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R12 back-to-back issue with the instruction held: doubleword increment twice
        mode64_en = 1'b1;
        preload(4'd3, 64'h0);
        stall_en = 1'b1;
        s_acc = acc_n; s_wr = wr_n;
        issue_instr = ins(MJ, 5'd0, 5'd20, 5'b00011, MN); issue_base = 64'h18; issue_src = '0;
        issue_valid = 1'b1;
        for (int t = 0; t < 80 && acc_n < s_acc + 2; t++) @(negedge clk);
        issue_valid = 1'b0;
        for (int t = 0; t < 80 && wr_n < s_wr + 2; t++) @(negedge clk);
        repeat (2) @(negedge clk);
        stall_en = 1'b0;
        chk(acc_n - s_acc == 2, "R12", "two acceptances", 64'(acc_n - s_acc), 64'd2);
        chk(acc_cyc == acc_prev_wr + 1, "R12", "second accept after write", 64'(acc_cyc), 64'(acc_prev_wr + 1));
        chk(mem[3] == 64'd2, "R12", "both increments applied", mem[3], 64'd2);
        chk(last_wb_data == 64'd1, "R7", "second returns first result", last_wb_data, 64'd1);

        chk(lock_bad == 0, "R10", "lock high with every request", 64'(lock_bad), 64'd0);
        chk(hold_bad == 0, "R10", "stalled request held", 64'(hold_bad), 64'd0);
        chk(busy_bad == 0, "R12", "not ready while busy", 64'(busy_bad), 64'd0);
        // R6 covered by vec1, vec5 and vec11 (upper read bits are junk, upper source bits ignored)
        summary();
        $finish;
    end
endmodule